// File: doc/BRIEF.md
# Cassette Tape Controller Host Register Interface

This block sits between a host processor's I/O instruction decoder and a cassette tape controller's motion and transfer engine. The host presents a 3-bit operation code with a strobe, together with its 8-bit accumulator. The block answers in the same cycle with a skip decision and a return word. It also holds the command register that selects drive, function, enable and interrupt enable, and the sticky half of the status register.

The transfer engine reports events as single-cycle pulses: a character is ready, a CRC fault, the tape reached an end marker, or a file gap was crossed. The selected drive reports its live state: attached, protected and busy, plus a rewinding level. From these the block forms a 9-bit status word, flags an overrun when a character arrives while the previous one is still unclaimed, and raises a level interrupt request. A go operation either starts a new function, continues the one in flight, or is refused when a write-type function targets a protected drive. Only an accepted go yields a one-cycle pulse to the engine.

Top module: `cass_ctl_regs`

## Requirements
- R1: After reset the command fields are all zero, the data flag and all sticky status bits are clear, and `go_pulse` and `irq` are low.
- R2: Operation 4 (load command) returns the bitwise complement of `acc_in` on `rd_data` in the strobe cycle. From the next cycle the command fields decode the loaded byte: bit 7 enable, bit 6 unit, bits 5:3 function, bit 0 interrupt enable.
- R3: While the enable bit is clear, the status word is hidden: operation 7 returns zero, and the error and ready conditions count as false for skips and for the interrupt.
- R4: The status word holds bits 8 write-lock error, 7 CRC error, 6 timing error, 5 tape end reached, 4 file gap, 3 empty (not attached), 2 rewinding, 1 write locked and 0 ready (not busy). Rewinding is shown only while the drive is attached and busy, and only when a rewind was started or the drive reports rewinding. Write locked is protected, rewinding or empty. Operation 7 returns bits 7:0.
- R5: The data flag is set by `ev_data` and cleared by any go (operation 6) or clear (operation 0). Operation 1 skips when the flag is set.
- R6: An `ev_data` pulse that arrives while the data flag is already set, and with no go or clear in the same cycle, sets the timing error bit.
- R7: Operation 2 skips when any visible bit among 8:3 is set.
- R8: Operation 3 skips when the visible status shows ready and not empty.
- R9: Operation 5 skips when the data flag is set or when any visible error or ready bit is set.
- R10: A go with the drive idle, enabled and attached, that is not refused, starts the function. It clears bits 8, 7, 6, 5 and 4 and raises `go_pulse` for the one cycle after the strobe. Starting function 1 (rewind) marks the drive as rewinding.
- R11: A start of a write-type function (2 write, 4 file gap) on a protected drive is refused. It sets bit 8, clears bits 7, 6 and 4, keeps bit 5, and gives no `go_pulse`.
- R12: A go while the drive is busy gives `go_pulse` and leaves the status bits unchanged. A go while idle and disabled or unattached gives no pulse and no status change. Both clear the data flag.
- R13: `irq` is high exactly when interrupt enable is set and the data flag, a visible error bit or visible ready holds.
- R14: Operation 0 clears the command register, the data flag and every sticky status bit on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_stb | input | 1 | Host operation strobe, one cycle per operation |
| op_code | input | 3 | Host operation code |
| acc_in | input | 8 | Host accumulator value |
| drv_attached | input | 1 | Selected drive has a cassette |
| drv_protected | input | 1 | Selected drive is write protected |
| drv_busy | input | 1 | Transfer engine is running a function |
| drv_rewinding | input | 1 | Drive reports rewind in progress |
| ev_data | input | 1 | Pulse: a character is ready or was taken |
| ev_crc | input | 1 | Pulse: CRC fault |
| ev_edge | input | 1 | Pulse: tape beginning or end reached |
| ev_eof | input | 1 | Pulse: file gap crossed |
| skip | output | 1 | Skip decision for the strobed operation |
| rd_data | output | 8 | Word returned to the accumulator |
| cmd_enable | output | 1 | Command enable field |
| cmd_unit | output | 1 | Drive select field |
| cmd_func | output | 3 | Function field |
| cmd_ie | output | 1 | Interrupt enable field |
| go_pulse | output | 1 | One-cycle start or continue request to the engine |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong sticky bit appears on the very next status read and on the error skip in the same cycle. It also drives the interrupt line at once when interrupt enable is set, so a stuck or lost bit shows within one host operation. A wrong data flag shows on the next data-flag or any-flag skip and on `irq`. A wrong go decision shows one cycle after the strobe, as a missing or extra `go_pulse`, and on the following read as stale or wrongly cleared error bits. Command register faults show on the command outputs one cycle after the load, and on what status becomes visible.

// File: rtl/cass_ctl_pkg.sv
package cass_ctl_pkg;

  localparam int REG_W  = 8;
  localparam int STAT_W = 9;
  localparam int FUNC_W = 3;
  localparam int OP_W   = 3;
  localparam int UNIT_W = 1;
  localparam int STICKY_W = 5;

  // Host operation codes (software encodes these).
  typedef enum logic [OP_W-1:0] {
    OP_CLEAR    = 3'd0,
    OP_SKIP_DF  = 3'd1,
    OP_SKIP_ERR = 3'd2,
    OP_SKIP_RDY = 3'd3,
    OP_LOAD_A   = 3'd4,
    OP_SKIP_ANY = 3'd5,
    OP_GO       = 3'd6,
    OP_READ_B   = 3'd7
  } host_op_e;

  // Function field values.
  typedef enum logic [FUNC_W-1:0] {
    FN_READ      = 3'd0,
    FN_REWIND    = 3'd1,
    FN_WRITE     = 3'd2,
    FN_REV_FILE  = 3'd3,
    FN_GAP       = 3'd4,
    FN_REV_BLOCK = 3'd5,
    FN_CRC       = 3'd6,
    FN_FWD_FILE  = 3'd7
  } tape_fn_e;

  // Command register field positions.
  localparam int CA_EN   = 7;
  localparam int CA_UNIT = 6;
  localparam int CA_FN   = 3;
  localparam int CA_IE   = 0;

  // Status word bit positions.
  localparam int SB_RDY   = 0;
  localparam int SB_LOCK  = 1;
  localparam int SB_REW   = 2;
  localparam int SB_EMPTY = 3;
  localparam int SB_EOF   = 4;
  localparam int SB_EDGE  = 5;
  localparam int SB_TIM   = 6;
  localparam int SB_CRC   = 7;
  localparam int SB_WLE   = 8;

  localparam logic [STAT_W-1:0] ERR_MASK = 9'b1_1111_1000;
  localparam logic [STAT_W-1:0] RDY_MASK = 9'b0_0000_0001;

  typedef struct packed {
    logic              en;
    logic [UNIT_W-1:0] unit;
    tape_fn_e          fn;
    logic              ie;
  } cmd_a_t;

  // Sticky part, high to low: wle, crc, tim, edge, eof.
  typedef struct packed {
    logic wle;
    logic crc;
    logic tim;
    logic edge_hit;
    logic eof;
  } sticky_t;

  function automatic logic fn_writes(tape_fn_e f);
    return (f == FN_WRITE) || (f == FN_GAP);
  endfunction

  function automatic cmd_a_t decode_cmd(logic [REG_W-1:0] b);
    cmd_a_t c;
    c.en   = b[CA_EN];
    c.unit = b[CA_UNIT +: UNIT_W];
    c.fn   = tape_fn_e'(b[CA_FN +: FUNC_W]);
    c.ie   = b[CA_IE];
    return c;
  endfunction

  function automatic logic [STAT_W-1:0] build_status(
    sticky_t s, logic att, logic prot, logic busy, logic rew_live);
    logic empty, rew, lock;
    empty = ~att;
    rew   = att & busy & rew_live;
    lock  = prot | rew | empty;
    return {s, empty, rew, lock, ~busy};
  endfunction

  function automatic logic skip_for(host_op_e op, logic df,
                                    logic [STAT_W-1:0] vis);
    logic any_err;
    any_err = |(vis & ERR_MASK);
    case (op)
      OP_SKIP_DF:  return df;
      OP_SKIP_ERR: return any_err;
      OP_SKIP_RDY: return vis[SB_RDY] & ~vis[SB_EMPTY];
      OP_SKIP_ANY: return df | any_err | vis[SB_RDY];
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cass_cmd_reg.sv
module cass_cmd_reg
  import cass_ctl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] din,
  output cmd_a_t       cmd
);

  cmd_a_t cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      cmd_q <= '0;
    else if (load)
      cmd_q <= decode_cmd(din);
  end

  // Bits 2:1 of the loaded byte carry no field.
  logic unused_spare;
  assign unused_spare = ^din[2:1];

  assign cmd = cmd_q;

endmodule

// File: rtl/cass_go_ctl.sv
module cass_go_ctl
  import cass_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go_req,
  input  logic     en,
  input  tape_fn_e fn,
  input  logic     att,
  input  logic     prot,
  input  logic     busy,
  output logic     go_start,
  output logic     go_abort,
  output logic     go_cont,
  output logic     start_rewind,
  output logic     go_pulse
);

  logic can_start;
  logic refused;

  assign can_start    = go_req & ~busy & en & att;
  assign refused      = fn_writes(fn) & prot;
  assign go_start     = can_start & ~refused;
  assign go_abort     = can_start & refused;
  assign go_cont      = go_req & busy;
  assign start_rewind = go_start & (fn == FN_REWIND);

  always_ff @(posedge clk) begin
    if (!rst_n)
      go_pulse <= 1'b0;
    else
      go_pulse <= go_start | go_cont;
  end

endmodule

// File: rtl/cass_stat_reg.sv
module cass_stat_reg
  import cass_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              go_req,
  input  logic              go_start,
  input  logic              go_abort,
  input  logic              start_rewind,
  input  logic              ev_data,
  input  logic              ev_crc,
  input  logic              ev_edge,
  input  logic              ev_eof,
  input  logic              att,
  input  logic              prot,
  input  logic              busy,
  input  logic              drv_rew,
  output logic [STAT_W-1:0] stat_word,
  output logic              df,
  output logic              overrun
);

  sticky_t s_q, s_d;
  logic    df_q, df_d;
  logic    rew_q, rew_d;
  logic    begin_op;

  assign begin_op = go_start | go_abort;
  assign overrun  = ev_data & df_q & ~go_req;

  always_comb begin
    s_d   = s_q;
    df_d  = df_q;
    rew_d = rew_q;
    if (begin_op) begin
      s_d.wle = go_abort;
      s_d.crc = 1'b0;
      s_d.tim = 1'b0;
      s_d.eof = 1'b0;
      rew_d   = start_rewind;
    end
    if (go_start)
      s_d.edge_hit = 1'b0;
    if (go_req)
      df_d = 1'b0;
    if (ev_data)
      df_d = 1'b1;
    if (overrun)
      s_d.tim = 1'b1;
    if (ev_crc)
      s_d.crc = 1'b1;
    if (ev_edge)
      s_d.edge_hit = 1'b1;
    if (ev_eof)
      s_d.eof = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      s_q   <= '0;
      df_q  <= 1'b0;
      rew_q <= 1'b0;
    end else begin
      s_q   <= s_d;
      df_q  <= df_d;
      rew_q <= rew_d;
    end
  end

  assign stat_word = build_status(s_q, att, prot, busy, rew_q | drv_rew);
  assign df        = df_q;

endmodule

// File: rtl/cass_host_resp.sv
module cass_host_resp
  import cass_ctl_pkg::*;
(
  input  logic              op_stb,
  input  host_op_e          op,
  input  logic [REG_W-1:0]  acc_in,
  input  logic              en,
  input  logic              ie,
  input  logic              df,
  input  logic [STAT_W-1:0] stat_word,
  output logic              skip,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq,
  output logic [STAT_W-1:0] vis_word
);

  assign vis_word = en ? stat_word : '0;
  assign skip     = op_stb & skip_for(op, df, vis_word);
  assign irq      = ie & (df | (|(vis_word & (ERR_MASK | RDY_MASK))));

  always_comb begin
    rd_data = acc_in;
    if (op_stb) begin
      case (op)
        OP_LOAD_A: rd_data = ~acc_in;
        OP_READ_B: rd_data = vis_word[REG_W-1:0];
        default:   rd_data = acc_in;
      endcase
    end
  end

endmodule

// File: rtl/cass_ctl_regs.sv
module cass_ctl_regs
  import cass_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_stb,
  input  logic [2:0] op_code,
  input  logic [7:0] acc_in,
  input  logic       drv_attached,
  input  logic       drv_protected,
  input  logic       drv_busy,
  input  logic       drv_rewinding,
  input  logic       ev_data,
  input  logic       ev_crc,
  input  logic       ev_edge,
  input  logic       ev_eof,
  output logic       skip,
  output logic [7:0] rd_data,
  output logic       cmd_enable,
  output logic       cmd_unit,
  output logic [2:0] cmd_func,
  output logic       cmd_ie,
  output logic       go_pulse,
  output logic       irq
);

  host_op_e          op;
  cmd_a_t            cmd;
  logic              go_req, clear_all, load_a;
  logic              go_start, go_abort, go_cont, start_rewind;
  logic              df_flag, overrun;
  logic [STAT_W-1:0] stat_word;
  logic [STAT_W-1:0] vis_word;

  assign op        = host_op_e'(op_code);
  assign go_req    = op_stb & (op == OP_GO);
  assign clear_all = op_stb & (op == OP_CLEAR);
  assign load_a    = op_stb & (op == OP_LOAD_A);

  cass_cmd_reg #(.W(REG_W)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_a),
    .clear (clear_all),
    .din   (acc_in),
    .cmd   (cmd)
  );

  cass_go_ctl u_go (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_req       (go_req),
    .en           (cmd.en),
    .fn           (cmd.fn),
    .att          (drv_attached),
    .prot         (drv_protected),
    .busy         (drv_busy),
    .go_start     (go_start),
    .go_abort     (go_abort),
    .go_cont      (go_cont),
    .start_rewind (start_rewind),
    .go_pulse     (go_pulse)
  );

  cass_stat_reg u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_all    (clear_all),
    .go_req       (go_req),
    .go_start     (go_start),
    .go_abort     (go_abort),
    .start_rewind (start_rewind),
    .ev_data      (ev_data),
    .ev_crc       (ev_crc),
    .ev_edge      (ev_edge),
    .ev_eof       (ev_eof),
    .att          (drv_attached),
    .prot         (drv_protected),
    .busy         (drv_busy),
    .drv_rew      (drv_rewinding),
    .stat_word    (stat_word),
    .df           (df_flag),
    .overrun      (overrun)
  );

  cass_host_resp u_resp (
    .op_stb    (op_stb),
    .op        (op),
    .acc_in    (acc_in),
    .en        (cmd.en),
    .ie        (cmd.ie),
    .df        (df_flag),
    .stat_word (stat_word),
    .skip      (skip),
    .rd_data   (rd_data),
    .irq       (irq),
    .vis_word  (vis_word)
  );

  assign cmd_enable = cmd.en;
  assign cmd_unit   = cmd.unit;
  assign cmd_func   = cmd.fn;
  assign cmd_ie     = cmd.ie;

endmodule

// File: rtl/cass_ctl_regs_chk.sv
module cass_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_stb,
  input logic [2:0] op_code,
  input logic [7:0] acc_in,
  input logic       drv_attached,
  input logic       drv_protected,
  input logic       drv_busy,
  input logic       ev_data,
  input logic       skip,
  input logic [7:0] rd_data,
  input logic       cmd_enable,
  input logic [2:0] cmd_func,
  input logic       cmd_ie,
  input logic       go_pulse,
  input logic       irq,
  input logic       df_flag,
  input logic [8:0] stat_word
);

  // R2: load echoes the complement in the strobe cycle
  a_r2_load_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 3'd4) |-> rd_data == ~acc_in);

  // R2: fields follow the loaded byte on the next cycle
  a_r2_load_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 3'd4) |=>
      (cmd_enable == $past(acc_in[7]) && cmd_ie == $past(acc_in[0]) &&
       cmd_func == $past(acc_in[5:3])));

  // R3: hidden status reads as zero
  a_r3_hidden_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 3'd7 && !cmd_enable) |-> rd_data == 8'h00);

  // R4: an empty drive is locked and never rewinding
  a_r4_empty_locks: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_attached |-> (stat_word[1] && stat_word[3] && !stat_word[2]));

  // R5: data flag skip follows the flag
  a_r5_df_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 3'd1) |-> skip == df_flag);

  // R6: a second character over an unclaimed one is a timing error
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && df_flag && !(op_stb && (op_code == 3'd6 || op_code == 3'd0)))
      |=> stat_word[6]);

  // R10: a go pulse always follows a go strobe
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |-> $past(op_stb && op_code == 3'd6));

  // R11: write-type start on a protected drive is refused
  a_r11_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 3'd6 && !drv_busy && cmd_enable && drv_attached &&
     drv_protected && (cmd_func == 3'd2 || cmd_func == 3'd4))
      |=> (!go_pulse && stat_word[8]));

  // R13: no request without interrupt enable
  a_r13_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmd_ie);

  // R14: clear empties command, flag and sticky bits
  a_r14_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 3'd0) |=>
      (!cmd_enable && !cmd_ie && !df_flag && stat_word[8:4] == 5'd0));

endmodule

bind cass_ctl_regs cass_ctl_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_stb        (op_stb),
  .op_code       (op_code),
  .acc_in        (acc_in),
  .drv_attached  (drv_attached),
  .drv_protected (drv_protected),
  .drv_busy      (drv_busy),
  .ev_data       (ev_data),
  .skip          (skip),
  .rd_data       (rd_data),
  .cmd_enable    (cmd_enable),
  .cmd_func      (cmd_func),
  .cmd_ie        (cmd_ie),
  .go_pulse      (go_pulse),
  .irq           (irq),
  .df_flag       (df_flag),
  .stat_word     (stat_word)
);

// File: tb/cass_ctl_regs_bench.sv
module cass_ctl_regs_bench;

  localparam int CLK_PERIOD = 10;

  localparam int K_SKIP = 0;
  localparam int K_RD   = 1;
  localparam int K_GO   = 2;
  localparam int K_IRQ  = 3;
  localparam int K_CMD  = 4;

  localparam logic [2:0] C_CLR = 3'd0, C_SDF = 3'd1, C_SERR = 3'd2,
    C_SRDY = 3'd3, C_LOAD = 3'd4, C_SANY = 3'd5, C_GO = 3'd6, C_RDB = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_stb = 1'b0;
  logic [2:0] op_code = '0;
  logic [7:0] acc_in = '0;
  logic       drv_attached = 1'b1, drv_protected = 1'b0;
  logic       drv_busy = 1'b0, drv_rewinding = 1'b0;
  logic       ev_data = 1'b0, ev_crc = 1'b0, ev_edge = 1'b0, ev_eof = 1'b0;
  logic       skip, cmd_enable, cmd_unit, cmd_ie, go_pulse, irq;
  logic [7:0] rd_data;
  logic [2:0] cmd_func;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string      req;
    int         kind;
    logic [8:0] exp;
  } item_t;

  item_t sb_q[$];
  event  ev_chk;

  always #(CLK_PERIOD/2) clk = ~clk;

  cass_ctl_regs u_cass_ctl_regs (
    .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op_code(op_code),
    .acc_in(acc_in), .drv_attached(drv_attached),
    .drv_protected(drv_protected), .drv_busy(drv_busy),
    .drv_rewinding(drv_rewinding), .ev_data(ev_data), .ev_crc(ev_crc),
    .ev_edge(ev_edge), .ev_eof(ev_eof), .skip(skip), .rd_data(rd_data),
    .cmd_enable(cmd_enable), .cmd_unit(cmd_unit), .cmd_func(cmd_func),
    .cmd_ie(cmd_ie), .go_pulse(go_pulse), .irq(irq)
  );

  // Monitor: pops expected items and compares with the ports.
  initial begin
    forever begin
      @(ev_chk);
      while (sb_q.size() > 0) begin
        item_t      it;
        logic [8:0] act;
        it = sb_q[0];
        case (it.kind)
          K_SKIP:  act = {8'd0, skip};
          K_RD:    act = {1'b0, rd_data};
          K_GO:    act = {8'd0, go_pulse};
          K_IRQ:   act = {8'd0, irq};
          default: act = {3'd0, cmd_enable, cmd_unit, cmd_func, cmd_ie};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic expect_item(string req, int kind, logic [8:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    -> ev_chk;
    wait (sb_q.size() == 0);
  endtask

  task automatic issue(logic [2:0] code, logic [7:0] acc);
    @(negedge clk);
    op_stb = 1'b1; op_code = code; acc_in = acc;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_stb = 1'b0;
    #1;
  endtask

  task automatic pulse_ev(bit d, bit c, bit e, bit f);
    @(negedge clk);
    op_stb = 1'b0;
    ev_data = d; ev_crc = c; ev_edge = e; ev_eof = f;
    @(negedge clk);
    ev_data = 1'b0; ev_crc = 1'b0; ev_edge = 1'b0; ev_eof = 1'b0;
    #1;
  endtask

  task automatic read_b(string req, logic [7:0] exp);
    issue(C_RDB, 8'h00);
    expect_item(req, K_RD, {1'b0, exp});
  endtask

  task automatic try_skip(string req, logic [2:0] code, bit exp);
    issue(code, 8'h00);
    expect_item(req, K_SKIP, {8'd0, exp});
  endtask

  task automatic load_a(string req, logic [7:0] v);
    issue(C_LOAD, v);
    expect_item(req, K_RD, {1'b0, ~v});
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // Reset state
    expect_item("R1 command fields", K_CMD, 9'h000);
    expect_item("R1 irq", K_IRQ, 9'h0);
    expect_item("R1 go_pulse", K_GO, 9'h0);
    read_b("R1 R3 status hidden", 8'h00);
    try_skip("R3 ready hidden", C_SRDY, 1'b0);
    try_skip("R3 error hidden", C_SERR, 1'b0);

    // Enable, function read, interrupt enable
    load_a("R2 echo 81", 8'h81);
    expect_item("R2 fields 81", K_CMD, 9'h021);
    expect_item("R13 irq on ready", K_IRQ, 9'h1);
    read_b("R4 idle attached", 8'h01);
    try_skip("R8 ready skip", C_SRDY, 1'b1);
    try_skip("R7 no error", C_SERR, 1'b0);
    try_skip("R9 any on ready", C_SANY, 1'b1);
    try_skip("R5 flag clear", C_SDF, 1'b0);

    drv_protected = 1'b1;
    read_b("R4 protected locks", 8'h03);
    drv_attached = 1'b0;
    read_b("R4 empty", 8'h0B);
    try_skip("R8 empty blocks ready", C_SRDY, 1'b0);
    try_skip("R7 empty is error", C_SERR, 1'b1);
    drv_attached = 1'b1; drv_protected = 1'b0;

    // Busy drive, rewinding level
    drv_busy = 1'b1; drv_rewinding = 1'b1;
    read_b("R4 busy rewinding", 8'h06);
    drv_rewinding = 1'b0;
    read_b("R4 busy only", 8'h00);
    expect_item("R13 no irq while busy", K_IRQ, 9'h0);
    try_skip("R9 nothing pending", C_SANY, 1'b0);
    pulse_ev(0, 1, 0, 0);
    read_b("R4 crc sticky", 8'h80);
    issue(C_GO, 8'h00);
    idle();
    expect_item("R12 continue pulse", K_GO, 9'h1);
    read_b("R12 continue keeps status", 8'h80);
    drv_busy = 1'b0;

    // Data flag and overrun
    pulse_ev(1, 0, 0, 0);
    try_skip("R5 flag set", C_SDF, 1'b1);
    pulse_ev(1, 0, 0, 0);
    read_b("R6 overrun timing bit", 8'hC1);

    // Start clears errors and flag
    issue(C_GO, 8'h00);
    idle();
    expect_item("R10 start pulse", K_GO, 9'h1);
    idle();
    expect_item("R10 pulse one cycle", K_GO, 9'h0);
    read_b("R10 errors cleared", 8'h01);
    try_skip("R5 go clears flag", C_SDF, 1'b0);

    pulse_ev(0, 0, 1, 1);
    read_b("R4 edge and gap", 8'h31);
    try_skip("R7 gap is error", C_SERR, 1'b1);
    issue(C_GO, 8'h00);
    idle();
    read_b("R10 edge and gap cleared", 8'h01);

    // Refused write on protected drive
    load_a("R2 echo 90", 8'h90);
    drv_protected = 1'b1;
    issue(C_GO, 8'h00);
    idle();
    expect_item("R11 no pulse", K_GO, 9'h0);
    read_b("R11 wle not readable", 8'h03);
    try_skip("R11 wle is error", C_SERR, 1'b1);
    load_a("R2 echo A0", 8'hA0);
    pulse_ev(0, 0, 1, 0);
    issue(C_GO, 8'h00);
    idle();
    expect_item("R11 gap write refused", K_GO, 9'h0);
    read_b("R11 edge kept", 8'h23);
    drv_protected = 1'b0;
    issue(C_GO, 8'h00);
    idle();
    expect_item("R10 write start pulse", K_GO, 9'h1);
    read_b("R10 wle and edge cleared", 8'h01);
    try_skip("R10 no error left", C_SERR, 1'b0);

    // Rewind start
    load_a("R2 echo 88", 8'h88);
    issue(C_GO, 8'h00);
    @(negedge clk);
    op_stb = 1'b0; drv_busy = 1'b1;
    #1;
    expect_item("R10 rewind pulse", K_GO, 9'h1);
    read_b("R10 rewind shown", 8'h06);
    drv_busy = 1'b0;
    read_b("R4 rewind hidden when idle", 8'h01);

    // Disabled with interrupt enable
    load_a("R2 echo 01", 8'h01);
    expect_item("R3 R13 hidden ready no irq", K_IRQ, 9'h0);
    pulse_ev(1, 0, 0, 0);
    expect_item("R13 flag raises irq", K_IRQ, 9'h1);
    try_skip("R9 flag alone", C_SANY, 1'b1);
    issue(C_GO, 8'h00);
    idle();
    expect_item("R12 disabled go no pulse", K_GO, 9'h0);
    try_skip("R12 disabled go clears flag", C_SDF, 1'b0);

    // Clear all
    load_a("R2 echo C9", 8'hC9);
    pulse_ev(0, 1, 0, 0);
    pulse_ev(1, 0, 0, 0);
    issue(C_CLR, 8'h00);
    idle();
    expect_item("R14 command cleared", K_CMD, 9'h000);
    expect_item("R14 irq low", K_IRQ, 9'h0);
    try_skip("R14 flag cleared", C_SDF, 1'b0);
    load_a("R2 echo C0", 8'hC0);
    expect_item("R2 unit field", K_CMD, 9'h030);
    read_b("R14 sticky cleared", 8'h01);

    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule